// File: doc/BRIEF.md
# Ring-Buffer Delay Address Generator

This block computes the delay-memory address for an audio effects processor that runs a fixed program of 128 steps per sample frame. On each step that asks for a memory read or write, the block adds together four terms: a base word taken from a per-step table, an optional 12-bit offset register, an optional +1, and a rotating frame counter. It then wraps the sum to the ring length and turns the word address into a byte address by adding the ring-buffer base pointer. The result is issued one cycle later as a request strobe, together with a write flag.

The rotating counter makes a fixed program walk through the delay ring. It starts at 1, steps down once at the end of every frame, and reloads to the ring length whenever it reaches zero. In table mode the counter and the ring wrap are skipped, so fixed lookup tables can be addressed directly. The same counter also rotates the 7-bit index into the temporary register file.

Reads complete two steps late. The block therefore gives a four-entry staging slot number with each request, and a separate slot number from which an input-write step takes its value.

Top module: `ring_addr_gen`

## Requirements
- R1: `mem_req` rises for exactly one cycle, in the cycle after a step on which `step_valid` is high, bit 0 of `step_idx` is 1 (an odd step) and at least one of `rd_req` or `wr_req` is set. `mem_we` then equals that step's `wr_req`. Even steps, idle cycles and steps with neither request produce no request.
- R2: The word sum is `base_word`, plus `ofs_word` when `ofs_en` is set, plus 1 when `inc_en` is set, plus the rotating counter when `tbl_mode` is clear.
- R3: With `tbl_mode` clear, `mem_word` is the sum ANDed with `ring_mask`. With `tbl_mode` set, `mem_word` is the low 16 bits of the sum, and both the counter and `ring_mask` have no effect.
- R4: `mem_byte` = (`mem_word` × 2 + `ring_ptr`) modulo 2^24.
- R5: The rotating counter is 1 after reset. It changes only on a valid step 127. At that step it becomes counter−1, or `ring_mask`+1 when counter−1 would be 0. Address and temp index for step 127 itself use the old value.
- R6: `tmp_idx` = (`tmp_field` + counter) modulo 128, combinationally.
- R7: `mem_slot` = (step+2) modulo 4 of the requesting step, registered alongside `mem_req`. `in_slot` = `step_idx` modulo 4, combinationally.
- R8: While `rst_n` is low, `mem_req` is 0 and `tmp_idx` equals `tmp_field`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | A program step executes this cycle |
| step_idx | input | 7 | Index of the executing step |
| rd_req | input | 1 | Step reads delay memory |
| wr_req | input | 1 | Step writes delay memory |
| tbl_mode | input | 1 | Table access: no rotation, 16-bit wrap |
| ofs_en | input | 1 | Add offset register |
| inc_en | input | 1 | Add one |
| base_word | input | 16 | Base word looked up for this step |
| ofs_word | input | 12 | Offset register value |
| ring_mask | input | 16 | Ring length minus one (0x7FFF by default) |
| ring_ptr | input | 24 | Ring base byte address |
| tmp_field | input | 7 | Temp register field of the step |
| tmp_idx | output | 7 | Rotated temp register index |
| in_slot | output | 2 | Staging slot read by an input write |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_word | output | 16 | Wrapped word address |
| mem_byte | output | 24 | Byte address |
| mem_slot | output | 2 | Staging slot that receives read data |

## Verification
Stimulus runs with several ring masks. A 4-word mask and a 16-word mask make the counter reload many times, which exposes off-by-one faults in the reload value and in the timing of the frame-end update. The full 32K mask and a 64K table-only run with base words near 0xFFFF check that the table path wraps at 16 bits and ignores both the counter and the mask. Runs with random idle cycles confirm that the counter steps only on a valid step 127. Random mixes of read/write flags on odd and even steps separate the odd-step gating from the write flag.

// File: rtl/ring_addr_gen.sv
module ring_addr_gen #(
  parameter int STEPS  = 128,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 24,
  parameter int OFS_W  = 12,
  parameter int TMP_W  = 7,
  parameter int SLOTS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      step_valid,
  input  logic [$clog2(STEPS)-1:0]  step_idx,
  input  logic                      rd_req,
  input  logic                      wr_req,
  input  logic                      tbl_mode,
  input  logic                      ofs_en,
  input  logic                      inc_en,
  input  logic [WORD_W-1:0]         base_word,
  input  logic [OFS_W-1:0]          ofs_word,
  input  logic [WORD_W-1:0]         ring_mask,
  input  logic [BYTE_W-1:0]         ring_ptr,
  input  logic [TMP_W-1:0]          tmp_field,
  output logic [TMP_W-1:0]          tmp_idx,
  output logic [$clog2(SLOTS)-1:0]  in_slot,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [WORD_W-1:0]         mem_word,
  output logic [BYTE_W-1:0]         mem_byte,
  output logic [$clog2(SLOTS)-1:0]  mem_slot
);
  localparam int STEP_W = $clog2(STEPS);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CT_W   = WORD_W + 1;
  localparam int SUM_W  = WORD_W + 3;

  logic [CT_W-1:0] ct;

  wire frame_end = step_valid && (step_idx == STEP_W'(STEPS - 1));
  wire [CT_W-1:0] ct_dec = ct - CT_W'(1);
  wire [CT_W-1:0] ct_reload = CT_W'(ring_mask) + CT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ct <= CT_W'(1);
    else if (frame_end)
      ct <= (ct_dec == '0) ? ct_reload : ct_dec;
  end

  wire access = step_valid && step_idx[0] && (rd_req || wr_req);

  wire [SUM_W-1:0] sum = SUM_W'(base_word)
                       + (ofs_en ? SUM_W'(ofs_word) : SUM_W'(0))
                       + SUM_W'(inc_en)
                       + (tbl_mode ? SUM_W'(0) : SUM_W'(ct));

  wire [WORD_W-1:0] word = tbl_mode ? sum[WORD_W-1:0]
                                    : (sum[WORD_W-1:0] & ring_mask);
  wire [BYTE_W-1:0] byte_addr = BYTE_W'({word, 1'b0}) + ring_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req  <= 1'b0;
      mem_we   <= 1'b0;
      mem_word <= '0;
      mem_byte <= '0;
      mem_slot <= '0;
    end else begin
      mem_req <= access;
      if (access) begin
        mem_we   <= wr_req;
        mem_word <= word;
        mem_byte <= byte_addr;
        mem_slot <= step_idx[SLOT_W-1:0] + SLOT_W'(2);
      end
    end
  end

  assign tmp_idx = tmp_field + ct[TMP_W-1:0];
  assign in_slot = step_idx[SLOT_W-1:0];

  AST_REQ_ODD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(step_valid && step_idx[0])); // R1

  AST_RING_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !$past(tbl_mode)) |-> ((mem_word & ~$past(ring_mask)) == '0)); // R3

  AST_BYTE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_byte[0] == $past(ring_ptr[0]))); // R4

  AST_CT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(ct)); // R5

  AST_CT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && ct == CT_W'(1)) |=> (ct == CT_W'($past(ring_mask)) + CT_W'(1))); // R5

  AST_CT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ct != '0); // R5
endmodule

// File: tb/tb_ring_addr_gen.sv
module tb_ring_addr_gen;
  localparam int PERIOD = 10;
  localparam int STEPS  = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_valid = 1'b0;
  logic [6:0]  step_idx = '0;
  logic        rd_req = 1'b0, wr_req = 1'b0, tbl_mode = 1'b0, ofs_en = 1'b0, inc_en = 1'b0;
  logic [15:0] base_word = '0;
  logic [11:0] ofs_word = '0;
  logic [15:0] ring_mask = 16'h7FFF;
  logic [23:0] ring_ptr = '0;
  logic [6:0]  tmp_field = 7'd5;
  logic [6:0]  tmp_idx;
  logic [1:0]  in_slot;
  logic        mem_req, mem_we;
  logic [15:0] mem_word;
  logic [23:0] mem_byte;
  logic [1:0]  mem_slot;

  ring_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_idx(step_idx),
    .rd_req(rd_req), .wr_req(wr_req), .tbl_mode(tbl_mode), .ofs_en(ofs_en),
    .inc_en(inc_en), .base_word(base_word), .ofs_word(ofs_word),
    .ring_mask(ring_mask), .ring_ptr(ring_ptr), .tmp_field(tmp_field),
    .tmp_idx(tmp_idx), .in_slot(in_slot), .mem_req(mem_req), .mem_we(mem_we),
    .mem_word(mem_word), .mem_byte(mem_byte), .mem_slot(mem_slot)
  );

  always #(PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  longint ct_m = 1;
  int s_idx = 0;
  bit e_req = 0, e_we = 0;
  longint e_word = 0, e_byte = 0, e_slot = 0;
  bit e_tbl = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(input bit gaps, input int tmode);
    bit v;
    longint sum, ct_before;
    @(negedge clk);
    chk("R1 req", mem_req, e_req);
    if (e_req) begin
      chk("R1 we", mem_we, e_we);
      chk(e_tbl ? "R3 table word" : "R2 ring word", mem_word, e_word);
      chk("R4 byte", mem_byte, e_byte);
      chk("R7 fill slot", mem_slot, e_slot);
    end
    v = gaps ? ($urandom % 5 != 0) : 1'b1;
    step_valid = v;
    step_idx   = 7'(s_idx);
    rd_req     = $urandom % 2;
    wr_req     = $urandom % 2;
    tbl_mode   = (tmode == 2) ? 1'($urandom % 2) : 1'(tmode);
    ofs_en     = $urandom % 2;
    inc_en     = $urandom % 2;
    base_word  = ($urandom % 3 == 0) ? 16'(16'hFFF0 + $urandom % 16) : 16'($urandom);
    ofs_word   = 12'($urandom);
    tmp_field  = 7'($urandom);
    ct_before = ct_m;
    sum = longint'(base_word) + (ofs_en ? longint'(ofs_word) : 0) + longint'(inc_en)
        + (tbl_mode ? 0 : ct_m);
    e_tbl  = tbl_mode;
    e_req  = v && (s_idx % 2 == 1) && (rd_req || wr_req);
    e_we   = wr_req;
    e_word = tbl_mode ? (sum % 65536) : ((sum % 65536) & longint'(ring_mask));
    e_byte = (e_word * 2 + longint'(ring_ptr)) % (64'd1 << 24);
    e_slot = (s_idx + 2) % 4;
    if (v) begin
      if (s_idx == STEPS - 1) begin
        ct_m = ct_m - 1;
        if (ct_m == 0) ct_m = longint'(ring_mask) + 1;
      end
      s_idx = (s_idx + 1) % STEPS;
    end
    #1;
    chk("R6 tmp idx", tmp_idx, (longint'(tmp_field) + ct_before) % 128);
    chk("R7 in slot", in_slot, longint'(step_idx) % 4);
  endtask

  task automatic phase(input logic [15:0] mask, input bit gaps, input int tmode, input int n);
    @(negedge clk);
    ring_mask = mask;
    ring_ptr  = 24'($urandom);
    e_req = 0;
    step_valid = 0;
    for (int i = 0; i < n; i++) cycle(gaps, tmode);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    if (!done) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tmp_field = 7'd5;
    rd_req = 1; wr_req = 1; step_valid = 1; step_idx = 7'd1;
    #1;
    chk("R8 reset req", mem_req, 0);
    chk("R8 reset tmp idx", tmp_idx, 6);
    @(negedge clk);
    chk("R8 reset req held", mem_req, 0);
    step_valid = 0; rd_req = 0; wr_req = 0;
    rst_n = 1;
    e_req = 0;
    phase(16'h000F, 0, 2, 20 * STEPS);
    phase(16'h0003, 1, 2, 12 * STEPS);
    phase(16'h7FFF, 0, 0, 3 * STEPS);
    phase(16'hFFFF, 1, 1, 3 * STEPS);
    phase(16'h7FFF, 0, 2, 2 * STEPS);
    cycle(0, 2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule